// File: doc/BRIEF.md
# Vertex Attribute Stream Gatherer

The gatherer loads the vertex attributes of one batch (1 to 16 vertices) from memory into vertex pipe memory before a shader runs. Software describes up to eight attribute streams. Each stream has a base address, a byte size, a memory stride, and two row offsets: one used when the batch feeds a vertex shader and one used when it feeds a coordinate shader. A per-shader-type enable mask and a stream count taken from a command word choose which streams take part. The output is transposed. Each 32-bit attribute word lands in its own VPM row, and the column is the vertex number, so a row holds one attribute for every vertex of the batch.

A one-cycle `start` latches the command word, the selected mask, the vertex count and the reserved size. The descriptors must stay stable while `busy` is high. The controller moves through five states. IDLE waits for start. PICK searches for the next enabled stream. REQ issues one memory read. WAIT takes the returned word and writes it into VPM. DONE raises `done` for one cycle and returns to IDLE. The transitions are as follows. IDLE→PICK happens on start. PICK→REQ happens when a stream is found, and PICK→DONE when none is left. REQ→WAIT is unconditional. WAIT→REQ happens when more words or vertices remain in the stream, and WAIT→PICK happens after the last word of the last vertex.

Top module: `vtx_stream_gather`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `vpm_we` are all low.
- R2: The number of active streams is `cmd_word[2:0]`, where 0 means all eight. Streams numbered at or above that count are skipped. All other command bits are ignored.
- R3: When `use_coord` is 0, the vertex mask and the vertex offsets are used. When it is 1, the coordinate mask and the coordinate offsets are used. Mask bit i enables stream i.
- R4: For vertex v and word w of a stream, the read address is base + v*stride + 4*w. The stride is independent of the size, so bytes between vertices are never read.
- R5: The word returned for (v, w) is written to VPM row offset+w, column v, with the returned data unchanged.
- R6: Streams are handled in ascending number. Within a stream, vertices go from 0 to N-1, and for each vertex the words go in ascending address order.
- R7: At most one read is outstanding. After a request, no new request is made until `mem_valid` has returned the data.
- R8: A word whose row is at or beyond `reserve_bytes/4` is still read but is not written to VPM.
- R9: `done` is a single-cycle pulse that follows the last VPM write. With no stream enabled, it follows start without any read.
- R10: A stream contributes `size_m1[7:2]+1` words per vertex. The size is expected to be a multiple of 4.
- R11: `vert_count` (1..16) sets the number of vertices. Columns 0..`vert_count`-1 are written and no others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one batch (sampled in IDLE) |
| cmd_word | input | 32 | Command word; bits 2:0 give the active stream count |
| use_coord | input | 1 | 0 = vertex shader batch, 1 = coordinate shader batch |
| vert_count | input | 5 | Vertices in the batch, 1..16 |
| mask_vert | input | 8 | Stream enables for vertex shader batches |
| mask_coord | input | 8 | Stream enables for coordinate shader batches |
| reserve_bytes | input | 8 | VPM bytes reserved for attributes |
| str_base | input | 8x32 | Per-stream base byte address |
| str_size_m1 | input | 8x8 | Per-stream byte size minus one |
| str_stride | input | 8x8 | Per-stream byte distance between vertices |
| str_off_vert | input | 8x8 | Per-stream starting row, vertex shader |
| str_off_coord | input | 8x8 | Per-stream starting row, coordinate shader |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | 32 | Read byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| vpm_we | output | 1 | VPM write strobe |
| vpm_row | output | 6 | VPM row (attribute) |
| vpm_col | output | 4 | VPM column (vertex) |
| vpm_wdata | output | 32 | VPM write data |
| busy | output | 1 | Batch in progress |
| done | output | 1 | Batch complete pulse |

## Verification
Six batches are run. A vertex-shader batch and a coordinate-shader batch share the same descriptors and differ only in mask and offsets, which separates the two selection paths. A batch with a stride larger than the size, spread over non-adjacent streams with a partial vertex count, shows that gaps are skipped and that only the used columns are written. A batch with every mask bit set but a stream count of three isolates the count field. A batch with a small reserved size separates reading from writing. A batch with an empty mask shows that completion needs no traffic. Each memory word encodes its own address, so one data comparison checks the address, the row, the column and the ordering together.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PICK,
        S_REQ,
        S_WAIT,
        S_DONE
    } gth_state_e;
endpackage

// File: rtl/vsg_stream_pick.sv
module vsg_stream_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N),
    parameter int SW = $clog2(N + 1)
) (
    input  logic [N-1:0]  en,
    input  logic [SW-1:0] from,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N-1:0] cand;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_cand
            assign cand[gi] = en[gi] && (SW'(gi) >= from);
        end
    endgenerate

    // lowest-numbered candidate wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vsg_addr_calc.sv
module vsg_addr_calc #(
    parameter int ADDR_W = 32,
    parameter int VTX_W  = 4,
    parameter int WRD_W  = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [7:0]        stride,
    input  logic [7:0]        row_off,
    input  logic [VTX_W-1:0]  vtx,
    input  logic [WRD_W-1:0]  word,
    output logic [ADDR_W-1:0] addr,
    output logic [8:0]        row_full
);
    always_comb begin
        addr     = base + ADDR_W'(vtx) * ADDR_W'(stride) + ADDR_W'({word, 2'b00});
        row_full = {1'b0, row_off} + 9'(word);
    end
endmodule

// File: rtl/vtx_stream_gather.sv
module vtx_stream_gather
    import vsg_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int MAX_VERTS   = 16,
    parameter int VPM_ROWS    = 64,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    localparam int IW    = $clog2(NUM_STREAMS),
    localparam int SW    = $clog2(NUM_STREAMS + 1),
    localparam int VTX_W = $clog2(MAX_VERTS),
    localparam int NV_W  = VTX_W + 1,
    localparam int ROW_W = $clog2(VPM_ROWS),
    localparam int WRD_W = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic [31:0]                         cmd_word,
    input  logic                                use_coord,
    input  logic [NV_W-1:0]                     vert_count,
    input  logic [NUM_STREAMS-1:0]              mask_vert,
    input  logic [NUM_STREAMS-1:0]              mask_coord,
    input  logic [7:0]                          reserve_bytes,
    input  logic [NUM_STREAMS-1:0][ADDR_W-1:0]  str_base,
    input  logic [NUM_STREAMS-1:0][7:0]         str_size_m1,
    input  logic [NUM_STREAMS-1:0][7:0]         str_stride,
    input  logic [NUM_STREAMS-1:0][7:0]         str_off_vert,
    input  logic [NUM_STREAMS-1:0][7:0]         str_off_coord,
    output logic                                mem_req,
    output logic [ADDR_W-1:0]                   mem_addr,
    input  logic                                mem_valid,
    input  logic [DATA_W-1:0]                   mem_rdata,
    output logic                                vpm_we,
    output logic [ROW_W-1:0]                    vpm_row,
    output logic [VTX_W-1:0]                    vpm_col,
    output logic [DATA_W-1:0]                   vpm_wdata,
    output logic                                busy,
    output logic                                done
);
    gth_state_e state, nxt;

    logic [NUM_STREAMS-1:0] en_q, cnt_mask;
    logic                   coord_q;
    logic [NV_W-1:0]        nv_q;
    logic [5:0]             rsv_rows_q;
    logic [SW-1:0]          search_q;
    logic [IW-1:0]          cur_q;
    logic [VTX_W-1:0]       vtx_q;
    logic [WRD_W-1:0]       word_q;

    // active stream count from the command word (0 selects all)
    logic [SW-1:0] act_cnt;
    assign act_cnt = (cmd_word[IW-1:0] == '0) ? SW'(NUM_STREAMS) : SW'(cmd_word[IW-1:0]);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_STREAMS; gi++) begin : g_cnt
            assign cnt_mask[gi] = (SW'(gi) < act_cnt);
        end
    endgenerate

    logic          pick_found;
    logic [IW-1:0] pick_idx;

    vsg_stream_pick #(.N(NUM_STREAMS)) u_pick (
        .en    (en_q),
        .from  (search_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    logic [7:0]        sel_off;
    logic [WRD_W-1:0]  last_word;
    logic [8:0]        row_full;
    logic [ADDR_W-1:0] rd_addr;

    assign sel_off   = coord_q ? str_off_coord[cur_q] : str_off_vert[cur_q];
    assign last_word = str_size_m1[cur_q][7:2];

    vsg_addr_calc #(.ADDR_W(ADDR_W), .VTX_W(VTX_W), .WRD_W(WRD_W)) u_addr (
        .base     (str_base[cur_q]),
        .stride   (str_stride[cur_q]),
        .row_off  (sel_off),
        .vtx      (vtx_q),
        .word     (word_q),
        .addr     (rd_addr),
        .row_full (row_full)
    );

    logic row_ok, last_wd, last_vx;
    assign row_ok  = (row_full < {3'b000, rsv_rows_q});
    assign last_wd = (word_q == last_word);
    assign last_vx = (NV_W'(vtx_q) == nv_q - NV_W'(1));

    logic unused_bits;
    assign unused_bits = ^{cmd_word[31:IW], reserve_bytes[1:0], str_size_m1[cur_q][1:0]};

    // state register and batch counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            en_q       <= '0;
            coord_q    <= 1'b0;
            nv_q       <= '0;
            rsv_rows_q <= '0;
            search_q   <= '0;
            cur_q      <= '0;
            vtx_q      <= '0;
            word_q     <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                S_IDLE: if (start) begin
                    en_q       <= (use_coord ? mask_coord : mask_vert) & cnt_mask;
                    coord_q    <= use_coord;
                    nv_q       <= vert_count;
                    rsv_rows_q <= reserve_bytes[7:2];
                    search_q   <= '0;
                end
                S_PICK: if (pick_found) begin
                    cur_q  <= pick_idx;
                    vtx_q  <= '0;
                    word_q <= '0;
                end
                S_REQ: ;
                S_WAIT: if (mem_valid) begin
                    if (!last_wd) begin
                        word_q <= word_q + WRD_W'(1);
                    end else begin
                        word_q <= '0;
                        if (last_vx) search_q <= SW'(cur_q) + SW'(1);
                        else         vtx_q    <= vtx_q + VTX_W'(1);
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = S_PICK;
            S_PICK: nxt = pick_found ? S_REQ : S_DONE;
            S_REQ:  nxt = S_WAIT;
            S_WAIT: if (mem_valid) nxt = (last_wd && last_vx) ? S_PICK : S_REQ;
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        mem_req   = (state == S_REQ);
        mem_addr  = rd_addr;
        vpm_we    = (state == S_WAIT) && mem_valid && row_ok;
        vpm_row   = row_full[ROW_W-1:0];
        vpm_col   = vtx_q;
        vpm_wdata = mem_rdata;
    end

    // R7: a request is never followed directly by another
    p_single_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R5: VPM is written only with data that has just returned
    p_write_with_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vpm_we |-> mem_valid && busy);

    // R8: no write lands beyond the reserved rows
    p_row_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vpm_we |-> (9'(vpm_row) < 9'(rsv_rows_q)));

    // R11: columns stay inside the batch
    p_col_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vpm_we |-> (NV_W'(vpm_col) < nv_q));

    // R9: completion is a single-cycle pulse that ends the batch
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R3: only an enabled stream is ever read
    p_read_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> en_q[cur_q]);
endmodule

// File: tb/vtx_stream_gather_tb.sv
module vtx_stream_gather_tb;
    typedef struct packed {
        logic [5:0]  row;
        logic [3:0]  col;
        logic [31:0] data;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             start = 1'b0;
    logic [31:0]      cmd_word = '0;
    logic             use_coord = 1'b0;
    logic [4:0]       vert_count = 5'd1;
    logic [7:0]       mask_vert = '0, mask_coord = '0, reserve_bytes = '0;
    logic [7:0][31:0] str_base = '0;
    logic [7:0][7:0]  str_size_m1 = '0, str_stride = '0, str_off_vert = '0, str_off_coord = '0;
    logic             mem_req, mem_valid = 1'b0;
    logic [31:0]      mem_addr, mem_rdata = '0;
    logic             vpm_we, busy, done;
    logic [5:0]       vpm_row;
    logic [3:0]       vpm_col;
    logic [31:0]      vpm_wdata;

    vtx_stream_gather u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
        .use_coord(use_coord), .vert_count(vert_count), .mask_vert(mask_vert),
        .mask_coord(mask_coord), .reserve_bytes(reserve_bytes), .str_base(str_base),
        .str_size_m1(str_size_m1), .str_stride(str_stride), .str_off_vert(str_off_vert),
        .str_off_coord(str_off_coord), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .vpm_we(vpm_we), .vpm_row(vpm_row),
        .vpm_col(vpm_col), .vpm_wdata(vpm_wdata), .busy(busy), .done(done)
    );

    int   total = 0, bad = 0;
    int   reads = 0, exp_reads = 0;
    bit   pending = 1'b0;
    bit   finished = 1'b0;
    exp_t q[$];

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h00005A5A;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory responder: one word per request, latency 0..2 cycles
    initial begin
        logic [31:0] a;
        forever begin
            @(posedge clk);
            if (mem_req) begin
                pending = 1'b1;
                a = mem_addr;
                repeat (int'(a[3:2]) % 3) @(posedge clk);
                #1 mem_valid = 1'b1;
                mem_rdata = mem_word(a);
                @(posedge clk);
                #1 mem_valid = 1'b0;
                pending = 1'b0;
            end
        end
    end

    // monitor: pops expected writes in order (R4 address, R5 placement, R6 order)
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            reads++;
            check(!pending, "R7", "request while read outstanding", 1, 0);
        end
        if (rst_n && vpm_we) begin
            if (q.size() == 0) begin
                check(1'b0, "R8", "unexpected VPM write row/col", {vpm_row, vpm_col}, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(vpm_row == e.row && vpm_col == e.col && vpm_wdata == e.data,
                      "R4/R5/R6", "VPM write {row,col,data}",
                      {16'h0, 2'b0, vpm_row, vpm_col, vpm_wdata},
                      {16'h0, 2'b0, e.row, e.col, e.data});
            end
        end
    end

    // driver: builds the expected write list from the requirements
    task automatic run_batch(input string tag);
        int cnt;
        logic [7:0] m;
        cnt = (cmd_word[2:0] == 3'd0) ? 8 : int'(cmd_word[2:0]);   // R2
        m = use_coord ? mask_coord : mask_vert;                      // R3
        exp_reads = 0;
        reads = 0;
        for (int s = 0; s < 8; s++) begin
            if (m[s] && s < cnt) begin
                for (int v = 0; v < int'(vert_count); v++) begin
                    for (int w = 0; w <= int'(str_size_m1[s][7:2]); w++) begin   // R10
                        logic [31:0] a;
                        int row;
                        exp_t e;
                        a = str_base[s] + 32'(v) * 32'(str_stride[s]) + 32'(4 * w);
                        row = int'(use_coord ? str_off_coord[s] : str_off_vert[s]) + w;
                        exp_reads++;
                        if (row < int'(reserve_bytes[7:2])) begin             // R8
                            e.row = 6'(row);
                            e.col = 4'(v);
                            e.data = mem_word(a);
                            q.push_back(e);
                        end
                    end
                end
            end
        end
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check(q.size() == 0, "R9", {tag, " writes outstanding at done"}, q.size(), 0);
        check(reads == exp_reads, "R10", {tag, " read count"}, reads, exp_reads);
        q.delete();
        @(negedge clk);
        check(!done && !busy, "R9", {tag, " done single cycle"}, {done, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req && !vpm_we, "R1", "reset outputs",
              {busy, done, mem_req, vpm_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1", "idle after reset", {busy, done}, 0);

        // two streams, vertex shader picks stream 0 (R3)
        cmd_word = 32'h0001_2342;   // count 2, upper bits ignored (R2)
        mask_vert = 8'h01; mask_coord = 8'h02;
        str_base[0] = 32'h1000; str_size_m1[0] = 8'd11; str_stride[0] = 8'd12;
        str_base[1] = 32'h2000; str_size_m1[1] = 8'd27; str_stride[1] = 8'd28;
        str_off_coord[1] = 8'd4;
        vert_count = 5'd16; reserve_bytes = 8'd12; use_coord = 1'b0;
        run_batch("R3 vertex");

        // same descriptors, coordinate shader and its offset (R3, R5)
        use_coord = 1'b1; reserve_bytes = 8'd44;
        run_batch("R3 coord");

        // stride wider than size, scattered streams, partial batch (R4, R11)
        cmd_word = 32'h0000_0008; use_coord = 1'b0; mask_vert = 8'h25;
        for (int s = 0; s < 8; s++) begin
            str_base[s] = 32'h4000 + 32'(s) * 32'h400;
            str_size_m1[s] = 8'd7; str_stride[s] = 8'd20;
            str_off_vert[s] = 8'(2 * s);
        end
        vert_count = 5'd5; reserve_bytes = 8'd252;
        run_batch("R4 R11 gaps");

        // all mask bits, count 3 (R2, R6)
        cmd_word = 32'hABCD_0003; mask_vert = 8'hFF;
        for (int s = 0; s < 8; s++) begin
            str_size_m1[s] = 8'd3; str_stride[s] = 8'd4; str_off_vert[s] = 8'(s);
        end
        vert_count = 5'd3;
        run_batch("R2 count");

        // reserved size clips rows (R8)
        cmd_word = 32'h1; mask_vert = 8'h01; str_size_m1[0] = 8'd11; str_stride[0] = 8'd12;
        str_off_vert[0] = 8'd0; reserve_bytes = 8'd8; vert_count = 5'd4;
        run_batch("R8 reserve");

        // nothing enabled (R9)
        cmd_word = 32'h0; mask_vert = 8'h00;
        run_batch("R9 empty");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule